// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single up-counting timer channel that produces a pulse-width waveform on one output pin. Its count edges come from one of eight sources: four fixed divisions of the master clock, a slow clock, or one of three external clock inputs. The external and slow inputs are brought into the master clock domain by two-flop synchronisers. The selected clock can be inverted so that falling edges count. It can also be gated by the level of an external input, and accepted edges are kept at least a set number of master clocks apart.

The counter either runs freely and wraps, or returns to zero on the edge after it equals compare value C. The output goes high when the counter takes compare value A and low when it takes compare value C, so with A at half of C the output is a square wave. Compare matches and counter wrap are latched as status flags. A set/clear mask selects which flags raise the interrupt line. Software drives the channel through a small word-wide register port with an 8-entry address map.

Top module: `wtc_channel`

## Requirements
- R1: After reset the counter reads 0, the output pin and interrupt are low, the mask (address 6) and status (address 7) read 0, and the channel is stopped.
- R2: MODE (address 1) bits [2:0] pick the source: 0, 1, 2, 3 = master clock divided by 2, 8, 32, 128; 4 = slow clock; 5, 6, 7 = external input 0, 1, 2. Each accepted rising edge of the source advances the counter, which reads at address 0.
- R3: MODE bit 3 set makes falling edges of the source count and rising edges have no effect.
- R4: MODE bits [5:4] gate counting: 0 = no gate, 1, 2, 3 = edges count only while external input 0, 1, 2 is high.
- R5: With MODE bit 6 set, the counter runs 0..C (address 3) and becomes 0 on the edge after it equals C. With bit 6 clear it runs past C and wraps from all ones to 0.
- R6: The output pin goes high when the counter takes value A (address 2) and low when it takes value C. C wins when A equals C.
- R7: A counter wrap from all ones to 0 sets status bit 0.
- R8: Status bit 1 latches an A match and bit 2 a C match. Bit 3 shows that the channel is running. Reading address 7 clears bits [2:0], and an event in the same cycle stays set.
- R9: Writing ones to address 4 sets mask bits, and writing ones to address 5 clears them. Address 6 reads the mask. The interrupt is high while any latched status bit in [2:0] has its mask bit set.
- R10: Writes to address 0: bit 1 stops the channel (and wins over bit 0), bit 0 starts it and requests a reset, bit 2 requests a reset only. A requested reset zeroes the counter on the next accepted edge, not at once.
- R11: A write to MODE stops the channel, clears the mask and drives the output pin low. The counter holds its value.
- R12: Two accepted count edges are at least MIN_GAP master clocks apart, and an edge arriving sooner is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears status on address 7) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| slow_clk_i | input | 1 | Slow clock, asynchronous |
| ext_clk_i | input | 3 | External clock / gate inputs, asynchronous |
| tioa_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with an 8-bit counter, so a free-running wrap and its status flag occur within about a thousand master clocks. It sets the minimum edge spacing to four clocks. This thins the divide-by-2 source to one count every four clocks, and the thinning shows up as a measurable counter rate. The external inputs are pulsed slowly enough that every intended edge is accepted. This allows exact counter values for the inversion, gating, stop and reset-request sequences.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NUM_EXT = 3;
  localparam int SYNC_N  = NUM_EXT + 1;
  localparam int PRESC_W = 7;
  localparam int FLAG_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_MODE  = 3'd1,
    A_RA    = 3'd2,
    A_RC    = 3'd3,
    A_IEN   = 3'd4,
    A_IDIS  = 3'd5,
    A_IMASK = 3'd6,
    A_STAT  = 3'd7
  } addr_e;

  typedef struct packed {
    logic       rc_mode;
    logic [1:0] burst;
    logic       inv;
    logic [2:0] src;
  } mode_t;
endpackage

// File: rtl/wtc_clk_sel.sv
module wtc_clk_sel
  import wtc_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slow_clk_i,
  input  logic [NUM_EXT-1:0] ext_clk_i,
  input  logic [2:0]         src_i,
  input  logic               inv_i,
  input  logic [1:0]         burst_i,
  input  logic               run_i,
  output logic               tick_o
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);

  logic [SYNC_N-1:0]  raw;
  logic [SYNC_N-1:0]  sync;
  logic [PRESC_W-1:0] presc;
  logic               lvl, lvl_q, edge_hit, gate;
  logic [GAP_W-1:0]   gap_q;
  logic               unused_presc;

  assign raw = {slow_clk_i, ext_clk_i};

  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= raw[i];
        s2_q <= s1_q;
      end
    end
    assign sync[i] = s2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) presc <= '0;
    else         presc <= presc + 1'b1;
  end

  assign unused_presc = ^{presc[1], presc[3], presc[5]};

  always_comb begin
    case (src_i)
      3'd0:    lvl = presc[0];
      3'd1:    lvl = presc[2];
      3'd2:    lvl = presc[4];
      3'd3:    lvl = presc[6];
      3'd4:    lvl = sync[NUM_EXT];
      3'd5:    lvl = sync[0];
      3'd6:    lvl = sync[1];
      default: lvl = sync[2];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign edge_hit = inv_i ? (lvl_q & ~lvl) : (~lvl_q & lvl);
  assign gate     = (burst_i == 2'd0) ? 1'b1 : sync[burst_i - 2'd1];
  assign tick_o   = edge_hit & gate & run_i & (gap_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (tick_o)         gap_q <= GAP_W'(MIN_GAP - 1);
    else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
  end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_req_i,
  input  logic             mode_wr_i,
  input  logic             rc_mode_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trig_pend_o,
  output logic             tioa_o,
  output logic             ev_ovf_o,
  output logic             ev_ra_o,
  output logic             ev_rc_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             wrap, trig_q, tioa_q;

  assign wrap = rc_mode_i && (cnt_q == rc_i);

  always_comb begin
    if (trig_q || wrap) nxt = '0;
    else                nxt = cnt_q + 1'b1;
  end

  assign ev_ovf_o = tick_i & ~trig_q & ~wrap & (&cnt_q);
  assign ev_ra_o  = tick_i & (nxt == ra_i);
  assign ev_rc_o  = tick_i & (nxt == rc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
      tioa_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= nxt;
      // a request in the same cycle as an edge applies to the following edge
      if (trig_req_i)  trig_q <= 1'b1;
      else if (tick_i) trig_q <= 1'b0;
      if (tick_i) begin
        if (nxt == rc_i)      tioa_q <= 1'b0;
        else if (nxt == ra_i) tioa_q <= 1'b1;
      end else if (mode_wr_i) begin
        tioa_q <= 1'b0;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign trig_pend_o = trig_q;
  assign tioa_o      = tioa_q;
endmodule

// File: rtl/wtc_regs.sv
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ev_ovf_i,
  input  logic              ev_ra_i,
  input  logic              ev_rc_i,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  ra_o,
  output logic [CNT_W-1:0]  rc_o,
  output logic              run_o,
  output logic              trig_req_o,
  output logic              mode_wr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  mode_t             mode_q;
  logic [CNT_W-1:0]  ra_q, rc_q;
  logic [FLAG_W-1:0] imr_q, flags_q;
  logic              run_q, stat_rd;
  addr_e             addr;

  assign addr       = addr_e'(addr_i);
  assign stat_rd    = re_i && (addr == A_STAT);
  assign mode_wr_o  = we_i && (addr == A_MODE);
  assign trig_req_o = we_i && (addr == A_CTRL) &&
                      ((wdata_i[0] && !wdata_i[1]) || wdata_i[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ra_q    <= '0;
      rc_q    <= '0;
      imr_q   <= '0;
      run_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      if (we_i) begin
        case (addr)
          A_CTRL: begin
            if (wdata_i[1])      run_q <= 1'b0;
            else if (wdata_i[0]) run_q <= 1'b1;
          end
          A_MODE: begin
            mode_q <= mode_t'(wdata_i[$bits(mode_t)-1:0]);
            run_q  <= 1'b0;
            imr_q  <= '0;
          end
          A_RA:   ra_q  <= wdata_i[CNT_W-1:0];
          A_RC:   rc_q  <= wdata_i[CNT_W-1:0];
          A_IEN:  imr_q <= imr_q | wdata_i[FLAG_W-1:0];
          A_IDIS: imr_q <= imr_q & ~wdata_i[FLAG_W-1:0];
          default: ;
        endcase
      end
      flags_q <= (stat_rd ? '0 : flags_q) | {ev_rc_i, ev_ra_i, ev_ovf_i};
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata_o = DATA_W'(cnt_i);
      A_MODE:  rdata_o = DATA_W'(mode_q);
      A_RA:    rdata_o = DATA_W'(ra_q);
      A_RC:    rdata_o = DATA_W'(rc_q);
      A_IMASK: rdata_o = DATA_W'(imr_q);
      A_STAT:  rdata_o = DATA_W'({run_q, flags_q});
      default: rdata_o = '0;
    endcase
  end

  assign irq_o   = |(flags_q & imr_q);
  assign mode_o  = mode_q;
  assign ra_o    = ra_q;
  assign rc_o    = rc_q;
  assign run_o   = run_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MIN_GAP = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               slow_clk_i,
  input  logic [2:0]         ext_clk_i,
  output logic               tioa_o,
  output logic               irq_o
);
  mode_t             mode;
  logic [CNT_W-1:0]  cnt, ra, rc;
  logic              tick, running, trig_req, trig_pend, mode_wr;
  logic              ev_ovf, ev_ra, ev_rc;
  logic [FLAG_W-1:0] flags;

  wtc_clk_sel #(.MIN_GAP(MIN_GAP)) u_clk_sel (
    .clk_i, .rst_ni, .slow_clk_i, .ext_clk_i,
    .src_i(mode.src), .inv_i(mode.inv), .burst_i(mode.burst),
    .run_i(running), .tick_o(tick)
  );

  wtc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .tick_i(tick), .trig_req_i(trig_req), .mode_wr_i(mode_wr),
    .rc_mode_i(mode.rc_mode), .ra_i(ra), .rc_i(rc), .cnt_o(cnt),
    .trig_pend_o(trig_pend), .tioa_o, .ev_ovf_o(ev_ovf), .ev_ra_o(ev_ra),
    .ev_rc_o(ev_rc)
  );

  wtc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cnt_i(cnt), .ev_ovf_i(ev_ovf), .ev_ra_i(ev_ra),
    .ev_rc_i(ev_rc), .mode_o(mode), .ra_o(ra), .rc_o(rc), .run_o(running),
    .trig_req_o(trig_req), .mode_wr_o(mode_wr), .flags_o(flags),
    .rdata_o(reg_rdata_o), .irq_o
  );
endmodule

// File: rtl/wtc_channel_chk.sv
module wtc_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             trig_pend,
  input logic             rc_mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rc,
  input logic             running,
  input logic [2:0]       flags,
  input logic             tioa_o,
  input logic             irq_o,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [2:0]       wlow
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt)); // R2

  AST_RC_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !trig_pend && rc_mode && cnt == rc) |=> (cnt == '0)); // R5

  AST_TIOA_LOW_AT_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt) && cnt == rc) |-> !tioa_o); // R6

  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !trig_pend && !(rc_mode && cnt == rc) && (&cnt)) |=> flags[0]); // R7

  AST_IRQ_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd5 && (&wlow)) |=> !irq_o); // R9

  AST_MODE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd1) |=> !running); // R11

  AST_EDGE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R12
endmodule

bind wtc_channel wtc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tick, .trig_pend, .rc_mode(mode.rc_mode), .cnt, .rc,
  .running, .flags, .tioa_o, .irq_o, .reg_we_i, .reg_addr_i,
  .wlow(reg_wdata_i[2:0])
);

// File: tb/wtc_channel_tb.sv
module wtc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int MIN_GAP    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        slow = 1'b0;
  logic [2:0]  ext = '0;
  logic        tioa, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] mask;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  event smp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtc_channel #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .slow_clk_i(slow), .ext_clk_i(ext), .tioa_o(tioa), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] lo, logic [31:0] hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      if (lo == hi) $display("FAIL %s: actual %0d expected %0d", tag, act, lo);
      else $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // monitor: pops expected items as read data appears
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rdata & e.mask, e.lo, e.hi);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: pushes the expectation, then presents the read
  task automatic rd(logic [2:0] a, logic [31:0] lo, logic [31:0] hi,
                    logic [31:0] mask, string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.mask = mask; e.tag = tag;
    @(negedge clk);
    exp_q.push_back(e);
    re = 1'b1; addr = a;
    #2 -> smp_ev;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic rd_eq(logic [2:0] a, logic [31:0] v, string tag);
    rd(a, v, v, 32'hffff_ffff, tag);
  endtask

  task automatic ext_set(int idx, logic v);
    @(negedge clk);
    ext[idx] = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(int idx);
    ext_set(idx, 1'b1);
    ext_set(idx, 1'b0);
  endtask

  task automatic slow_pulse();
    @(negedge clk); slow = 1'b1;
    repeat (6) @(negedge clk);
    slow = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd_eq(3'd0, 0, "R1 counter");
    rd_eq(3'd6, 0, "R1 mask");
    rd_eq(3'd7, 0, "R1 status");
    check("R1 tioa", tioa, 0, 0);
    check("R1 irq", irq, 0, 0);

    // ext0 source, RC reset mode, A=2 C=4, C interrupt enabled
    wr(3'd1, 32'h45);
    wr(3'd2, 2);
    wr(3'd3, 4);
    wr(3'd4, 32'h4);
    wr(3'd0, 32'h1);
    pulse(0); rd_eq(3'd0, 0, "R10 start reset on first edge");
    pulse(0); rd_eq(3'd0, 1, "R2 ext edge counts");
    pulse(0); rd_eq(3'd0, 2, "R2 count 2");
    check("R6 tioa high at A", tioa, 1, 1);
    check("R9 irq masked A flag", irq, 0, 0);
    pulse(0);
    pulse(0); rd_eq(3'd0, 4, "R5 reaches C");
    check("R6 tioa low at C", tioa, 0, 0);
    check("R9 irq on C match", irq, 1, 1);
    rd(3'd7, 6, 6, 7, "R8 A and C flags");
    idle(1);
    check("R8 irq low after status read", irq, 0, 0);
    pulse(0); rd_eq(3'd0, 0, "R5 back to 0 after C");
    rd_eq(3'd6, 4, "R9 mask readback");
    wr(3'd5, 32'h4);
    rd_eq(3'd6, 0, "R9 disable clears mask");
    repeat (4) pulse(0);
    check("R9 irq stays low while masked", irq, 0, 0);
    rd(3'd7, 6, 6, 7, "R8 flags latched while masked");
    rd(3'd7, 0, 0, 7, "R8 cleared by read");

    // slow clock, free running
    wr(3'd1, 32'h4);
    wr(3'd0, 32'h1);
    repeat (3) slow_pulse();
    rd_eq(3'd0, 2, "R2 slow clock");

    // gate on ext1
    wr(3'd1, 32'h65);
    wr(3'd3, 100);
    ext_set(1, 1'b1);
    wr(3'd0, 32'h1);
    pulse(0); pulse(0);
    rd_eq(3'd0, 1, "R4 counts while gate high");
    ext_set(1, 1'b0);
    pulse(0); pulse(0);
    rd_eq(3'd0, 1, "R4 no count while gate low");
    ext_set(1, 1'b1);
    pulse(0);
    rd_eq(3'd0, 2, "R4 resumes");

    // inverted ext0
    wr(3'd1, 32'h4d);
    wr(3'd0, 32'h1);
    ext_set(0, 1'b1);
    rd_eq(3'd0, 2, "R3 rising edge ignored");
    ext_set(0, 1'b0);
    rd_eq(3'd0, 0, "R3 falling edge counts (reset)");
    pulse(0);
    rd_eq(3'd0, 1, "R3 falling edge increments");

    // stop / start / reset request
    wr(3'd0, 32'h2);
    pulse(0);
    rd_eq(3'd0, 1, "R10 stopped holds");
    rd(3'd7, 0, 0, 8, "R10 running bit clear");
    wr(3'd0, 32'h1);
    pulse(0); rd_eq(3'd0, 0, "R10 restart resets");
    pulse(0); pulse(0);
    rd_eq(3'd0, 2, "R10 counts after restart");
    wr(3'd0, 32'h4);
    rd_eq(3'd0, 2, "R10 reset request not immediate");
    pulse(0);
    rd_eq(3'd0, 0, "R10 reset on next edge");

    // mode write side effects
    wr(3'd1, 32'h45);
    wr(3'd2, 1);
    wr(3'd3, 100);
    wr(3'd0, 32'h1);
    pulse(0); pulse(0);
    check("R6 tioa high at A=1", tioa, 1, 1);
    wr(3'd4, 32'h7);
    rd_eq(3'd6, 7, "R9 enable sets mask");
    wr(3'd1, 32'h45);
    rd_eq(3'd6, 0, "R11 mode write clears mask");
    check("R11 tioa low", tioa, 0, 0);
    rd(3'd7, 0, 0, 8, "R11 channel stopped");
    pulse(0);
    rd_eq(3'd0, 1, "R11 counter held");

    // internal divisions
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h1);
    idle(400);
    rd(3'd0, 46, 51, 32'hff, "R2 master/8 rate");
    wr(3'd1, 32'h3);
    wr(3'd0, 32'h1);
    idle(1300);
    rd(3'd0, 7, 11, 32'hff, "R2 master/128 rate");
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h1);
    idle(400);
    rd(3'd0, 95, 101, 32'hff, "R12 master/2 thinned by gap");

    // free run wrap and overflow flag
    wr(3'd1, 32'h0);
    wr(3'd2, 20);
    wr(3'd3, 10);
    rd(3'd7, 0, 7, 0, "R8 clear before wrap");
    wr(3'd0, 32'h1);
    idle(1200);
    rd(3'd7, 1, 1, 1, "R7 overflow flag");
    rd(3'd0, 38, 47, 32'hff, "R5 free run wraps past C");
    rd(3'd7, 0, 0, 7, "R8 flags cleared after read");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule